// File: doc/BRIEF.md
# Bus-to-Register-Bank Access Controller

This block sits between a pipelined Wishbone master and a bank of control and status registers. It accepts a request when the master holds cyc and stb high while the block is not stalling. It latches the address, the write data and the direction. In the next cycle it raises exactly one single-cycle enable toward the bank: a write enable for a write and a read enable for a read. The block then waits for the bank's reply. For a write this is the bank's write-accepted acknowledge, and for a read it is the bank's read-data-valid flag.

Stall is held high toward the master from the enable cycle until the bank replies. In the reply cycle stall drops, so the master can hand over the next request of a burst at once. Back-to-back accesses therefore produce enables in consecutive cycles. The bus acknowledge is a registered one-cycle pulse in the cycle after the reply. On a read, the returned data is captured at the reply and appears on the data output together with that acknowledge.

An access the bank refuses is never acknowledged. The master ends such a transaction by dropping cyc, which returns the block to idle without an acknowledge. Reset is synchronous, and a parameter sets its polarity.

Top module: `wbs_csr_front`

## Requirements
- R1: While reset is applied and in the first cycle after it, ack, stall, the read enable and the write enable are all low.
- R2: A request is taken only when cyc and stb are both high and stall is low; cyc alone or stb alone never produces a bank enable.
- R3: In the cycle after a request is taken, exactly one bank enable is high for one cycle: the write enable when we was 1, the read enable when we was 0, with the latched address and write data on the bank outputs.
- R4: From the enable cycle until the cycle in which the bank replies, stall is high; in the reply cycle stall is low.
- R5: A write is acknowledged only after the bank's write-accepted acknowledge, and a read only after its read-data-valid flag. Ack is a one-cycle pulse in the cycle after the reply, so a reply delayed by L cycles after the enable gives ack L+2 cycles after the request cycle.
- R6: For a read, the bank's read data at the reply is shown on the bus data output in the ack cycle, and it holds until the next read reply.
- R7: In a burst, a request presented while stall is low in a reply cycle is taken at once. With zero-latency replies, two back-to-back writes keep the write enable high for two consecutive cycles, and each write gets its own ack.
- R8: An access that the bank never answers is not acknowledged, and stall stays high for as long as cyc is held.
- R9: If cyc goes low during a transaction, the block returns to idle in the next cycle (stall low) and no ack is given for that transaction, even if the bank replies later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, polarity set by RST_HIGH |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | AW | Register address |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data returned to the master |
| wb_ack_o | output | 1 | One-cycle transfer acknowledge |
| wb_stall_o | output | 1 | Request cannot be taken |
| bank_rd_en_o | output | 1 | Single-cycle read enable to the bank |
| bank_wr_en_o | output | 1 | Single-cycle write enable to the bank |
| bank_adr_o | output | AW | Latched address to the bank |
| bank_wdat_o | output | DW | Latched write data to the bank |
| bank_rdat_i | input | DW | Read data from the selected register |
| bank_rvalid_i | input | 1 | Read data valid (legal read) |
| bank_wack_i | input | 1 | Write data accepted (legal write) |

## Verification
Every result has a fixed arrival cycle counted from the request cycle C. The bank enable appears in C+1. With a bank latency of L, stall stays high through C+L and drops in C+L+1, and ack and the read data arrive in C+L+2. An abort is visible at the ports in the cycle after cyc falls. The bench drives inputs and samples outputs on the falling edge, and its bank model replies at a chosen latency of 0, 1 or 2. For each address it counts falling edges from the request and compares the cycle in which each event occurs with these formulas. It also checks that nothing occurs in the cycles between.

// File: rtl/wbs_csr_pkg.sv
package wbs_csr_pkg;

  // Reply that finishes the pending access: write-accepted for writes,
  // read-data-valid for reads.
  function automatic logic pick_reply(input logic is_write,
                                      input logic wack,
                                      input logic rvalid);
    return is_write ? wack : rvalid;
  endfunction

  // Normalise the reset pin to an active-high condition.
  function automatic logic rst_asserted(input bit pol_high, input logic rst);
    return pol_high ? rst : ~rst;
  endfunction

  // A new request is taken when the bus offers one and we are not stalling.
  function automatic logic take_request(input logic cyc, input logic stb,
                                        input logic stall);
    return cyc & stb & ~stall;
  endfunction

endpackage

// File: rtl/wbs_csr_accept.sv
module wbs_csr_accept
  import wbs_csr_pkg::*;
(
  input  logic cyc_i,
  input  logic stb_i,
  input  logic busy_i,
  input  logic wr_cycle_i,
  input  logic wack_i,
  input  logic rvalid_i,
  output logic reply_o,
  output logic stall_o,
  output logic accept_o
);

  always_comb begin
    reply_o  = busy_i & pick_reply(wr_cycle_i, wack_i, rvalid_i);
    stall_o  = busy_i & ~reply_o;
    accept_o = take_request(cyc_i, stb_i, stall_o);
  end

endmodule

// File: rtl/wbs_csr_track.sv
module wbs_csr_track #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_act_i,
  input  logic          cyc_i,
  input  logic          accept_i,
  input  logic          reply_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic          busy_o,
  output logic          issue_o,
  output logic          wr_cycle_o,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o
);

  always_ff @(posedge clk_i) begin
    if (rst_act_i) begin
      busy_o     <= 1'b0;
      issue_o    <= 1'b0;
      wr_cycle_o <= 1'b0;
      adr_o      <= '0;
      dat_o      <= '0;
    end else if (!cyc_i) begin
      busy_o  <= 1'b0;
      issue_o <= 1'b0;
    end else begin
      busy_o  <= accept_i | (busy_o & ~reply_i);
      issue_o <= accept_i;
      if (accept_i) begin
        wr_cycle_o <= we_i;
        adr_o      <= adr_i;
        dat_o      <= dat_i;
      end
    end
  end

endmodule

// File: rtl/wbs_csr_resp.sv
module wbs_csr_resp #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_act_i,
  input  logic          cyc_i,
  input  logic          reply_i,
  input  logic          wr_cycle_i,
  input  logic [DW-1:0] rdat_i,
  output logic          ack_o,
  output logic [DW-1:0] dat_o
);

  always_ff @(posedge clk_i) begin
    if (rst_act_i) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= reply_i & cyc_i;
      if (reply_i && !wr_cycle_i) dat_o <= rdat_i;
    end
  end

endmodule

// File: rtl/wbs_csr_front.sv
module wbs_csr_front
  import wbs_csr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_adr_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic [DW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  output logic          wb_stall_o,
  output logic          bank_rd_en_o,
  output logic          bank_wr_en_o,
  output logic [AW-1:0] bank_adr_o,
  output logic [DW-1:0] bank_wdat_o,
  input  logic [DW-1:0] bank_rdat_i,
  input  logic          bank_rvalid_i,
  input  logic          bank_wack_i
);

  // Named internal events, visible to the bound checker.
  logic rst_act;
  logic busy_w;
  logic issue_w;
  logic rd_cycle_w;
  logic wr_cycle_w;
  logic reply_w;
  logic accept_w;

  assign rst_act = rst_asserted(RST_HIGH, rst_i);

  wbs_csr_accept u_accept (
    .cyc_i      (wb_cyc_i),
    .stb_i      (wb_stb_i),
    .busy_i     (busy_w),
    .wr_cycle_i (wr_cycle_w),
    .wack_i     (bank_wack_i),
    .rvalid_i   (bank_rvalid_i),
    .reply_o    (reply_w),
    .stall_o    (wb_stall_o),
    .accept_o   (accept_w)
  );

  wbs_csr_track #(.AW(AW), .DW(DW)) u_track (
    .clk_i      (clk_i),
    .rst_act_i  (rst_act),
    .cyc_i      (wb_cyc_i),
    .accept_i   (accept_w),
    .reply_i    (reply_w),
    .we_i       (wb_we_i),
    .adr_i      (wb_adr_i),
    .dat_i      (wb_dat_i),
    .busy_o     (busy_w),
    .issue_o    (issue_w),
    .wr_cycle_o (wr_cycle_w),
    .adr_o      (bank_adr_o),
    .dat_o      (bank_wdat_o)
  );

  wbs_csr_resp #(.DW(DW)) u_resp (
    .clk_i      (clk_i),
    .rst_act_i  (rst_act),
    .cyc_i      (wb_cyc_i),
    .reply_i    (reply_w),
    .wr_cycle_i (wr_cycle_w),
    .rdat_i     (bank_rdat_i),
    .ack_o      (wb_ack_o),
    .dat_o      (wb_dat_o)
  );

  assign rd_cycle_w   = ~wr_cycle_w;
  assign bank_wr_en_o = issue_w & wr_cycle_w;
  assign bank_rd_en_o = issue_w & rd_cycle_w;

endmodule

// File: rtl/wbs_csr_front_chk.sv
module wbs_csr_front_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_act,
  input logic          wb_cyc_i,
  input logic          wb_stb_i,
  input logic          wb_we_i,
  input logic          wb_stall_o,
  input logic          wb_ack_o,
  input logic [DW-1:0] wb_dat_o,
  input logic          bank_rd_en_o,
  input logic          bank_wr_en_o,
  input logic          reply_w,
  input logic          rd_cycle_w
);

  p_strobe_after_accept_r2: assert property (@(posedge clk_i) disable iff (rst_act)
    (bank_rd_en_o || bank_wr_en_o) |-> $past(wb_cyc_i && wb_stb_i && !wb_stall_o));

  p_write_path_r3: assert property (@(posedge clk_i) disable iff (rst_act)
    bank_wr_en_o |-> $past(wb_we_i));

  p_read_path_r3: assert property (@(posedge clk_i) disable iff (rst_act)
    bank_rd_en_o |-> $past(!wb_we_i));

  p_stall_holds_r4: assert property (@(posedge clk_i) disable iff (rst_act)
    (wb_stall_o && wb_cyc_i) |=> (wb_stall_o || reply_w));

  p_ack_after_reply_r5: assert property (@(posedge clk_i) disable iff (rst_act)
    wb_ack_o |-> $past(reply_w && wb_cyc_i));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (rst_act)
    !(reply_w && rd_cycle_w) |=> $stable(wb_dat_o));

  p_abort_no_ack_r9: assert property (@(posedge clk_i) disable iff (rst_act)
    !wb_cyc_i |=> !wb_ack_o);

endmodule

bind wbs_csr_front wbs_csr_front_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_act      (rst_act),
  .wb_cyc_i     (wb_cyc_i),
  .wb_stb_i     (wb_stb_i),
  .wb_we_i      (wb_we_i),
  .wb_stall_o   (wb_stall_o),
  .wb_ack_o     (wb_ack_o),
  .wb_dat_o     (wb_dat_o),
  .bank_rd_en_o (bank_rd_en_o),
  .bank_wr_en_o (bank_wr_en_o),
  .reply_w      (reply_w),
  .rd_cycle_w   (rd_cycle_w)
);

// File: tb/tb_wbs_csr_front.sv
module tb_wbs_csr_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NREG = 16;
  localparam int NLEGAL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0;
  logic [DW-1:0] dat_o;
  logic ack, stall, rd_en, wr_en;
  logic [AW-1:0] b_adr;
  logic [DW-1:0] b_wdat, b_rdat;
  logic b_rvalid, b_wack;

  int errors = 0;
  int checks = 0;
  int lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbs_csr_front #(.AW(AW), .DW(DW), .RST_HIGH(1'b1)) dut (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .wb_stall_o(stall), .bank_rd_en_o(rd_en), .bank_wr_en_o(wr_en),
    .bank_adr_o(b_adr), .bank_wdat_o(b_wdat), .bank_rdat_i(b_rdat),
    .bank_rvalid_i(b_rvalid), .bank_wack_i(b_wack)
  );

  // Bank model: addresses below NLEGAL answer after lat cycles, others never.
  logic [DW-1:0] mem [NREG];
  int cnt;
  logic pend_we;
  logic legal;
  assign legal    = (int'(b_adr) < NLEGAL);
  assign b_wack   = legal & ((lat == 0) ? wr_en : (cnt == 1 && pend_we));
  assign b_rvalid = legal & ((lat == 0) ? rd_en : (cnt == 1 && !pend_we));
  assign b_rdat   = mem[b_adr];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= 0;
      pend_we <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (rd_en || wr_en) begin
        cnt     <= lat;
        pend_we <= wr_en;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end
      if (b_wack) mem[b_adr] <= b_wdat;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pattern(input int a, input int l);
    return (a * 7 + l * 29 + 3) & 255;
  endfunction

  // One transfer; request cycle C, enable in C+1, ack expected in C+lat+2.
  task automatic xfer(input bit w, input int a, input int d, input int exp_rd);
    bit got = 0;
    int ackn = 0;
    bit stall_ok = 1;
    int rd_val = 0;
    bit lg = (a < NLEGAL);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = AW'(a); wdat = DW'(d);
    @(negedge clk);
    stb = 0;
    check(wr_en == w && rd_en == !w, "R3", {30'd0, wr_en, rd_en}, {30'd0, w, !w});
    check(int'(b_adr) == a, "R3", int'(b_adr), a);
    if (w) check(int'(b_wdat) == d, "R3", int'(b_wdat), d);
    for (int n = 1; n <= 8 && !got; n++) begin
      if (n > 1) begin
        @(negedge clk);
        if (rd_en || wr_en) stall_ok = 0;
      end
      if (ack) begin got = 1; ackn = n; rd_val = int'(dat_o); end
      else if (lg && n <= lat && !stall) stall_ok = 0;
      else if (lg && n == lat + 1 && stall) stall_ok = 0;
    end
    check(stall_ok, "R4", stall_ok, 1);
    if (lg) begin
      check(got && ackn == lat + 2, "R5", ackn, lat + 2);
      if (!w) check(rd_val == exp_rd, "R6", rd_val, exp_rd);
      cyc = 0;
      @(negedge clk);
      check(!ack, "R5", ack, 0);
      if (!w) check(int'(dat_o) == exp_rd, "R6", int'(dat_o), exp_rd);
    end else begin
      check(!got, "R8", got, 0);
      check(stall, "R8", stall, 1);
      cyc = 0;
      @(negedge clk);
      check(!stall && !ack, "R9", {30'd0, stall, ack}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ack && !stall && !rd_en && !wr_en, "R1",
          {28'd0, ack, stall, rd_en, wr_en}, 0);
    rst = 0;
    @(negedge clk);
    check(!ack && !stall && !rd_en && !wr_en, "R1",
          {28'd0, ack, stall, rd_en, wr_en}, 0);

    // R2: cyc without stb, then stb without cyc.
    cyc = 1; stb = 0; we = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!rd_en && !wr_en && !stall, "R2", {30'd0, rd_en, wr_en}, 0);
    end
    cyc = 0; stb = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!rd_en && !wr_en && !stall, "R2", {30'd0, rd_en, wr_en}, 0);
    end
    stb = 0;

    // Sweep: every address at each bank latency, write then read back.
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int a = 0; a < NREG; a++) xfer(1'b1, a, pattern(a, l), 0);
      for (int a = 0; a < NREG; a++)
        if (a < NLEGAL) xfer(1'b0, a, 0, pattern(a, l));
        else xfer(1'b0, a, 0, 0);
    end

    // R7: burst of two writes at zero latency.
    lat = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 4'd1; wdat = 8'h11;
    @(negedge clk);
    check(wr_en && !stall, "R7", {30'd0, wr_en, stall}, 2);
    adr = 4'd2; wdat = 8'h22;
    @(negedge clk);
    check(wr_en && ack, "R7", {30'd0, wr_en, ack}, 3);
    stb = 0;
    @(negedge clk);
    check(ack && !wr_en, "R7", {30'd0, ack, wr_en}, 2);
    cyc = 0;
    @(negedge clk);
    check(!ack, "R7", ack, 0);
    xfer(1'b0, 1, 0, 8'h11);
    xfer(1'b0, 2, 0, 8'h22);

    // R9: abort a legal read while the bank is still counting.
    lat = 2;
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 4'd3;
    @(negedge clk);
    stb = 0;
    cyc = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!ack && !stall, "R9", {30'd0, ack, stall}, 0);
    end
    // Block still works after the abort.
    xfer(1'b0, 3, 0, pattern(3, 2));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule